// File: doc/BRIEF.md
# Card Pairing and Rekey Button Controller

This block is the control state machine for an encrypted volume that is spread over two removable memory cards. It keeps both cards unpowered and isolated from the shared card bus until both slots are occupied. It then applies power, waits a settling interval with the bus still isolated, connects the bus and asks the card-reading logic to fetch the two key-storage blocks. The four flags that come back decide whether the pair is consistent. A consistent pair is mounted for the host. An inconsistent pair lights a steady error indicator and is not mounted.

One push-button has two uses. When the error indicator is steady, a debounced press starts key initialisation of both cards at once, and the volume is mounted afterwards. When the volume is mounted, a press makes the indicator blink. Releasing the button early cancels the action. Holding it for the full hold time stops the blink and runs an unmount, a key regeneration and a remount, in that order. Reading the cards, generating randomness and all cryptography sit outside the block. Each appears only as a request output that stays high until a one-cycle done input.

All timing counts a one-cycle millisecond tick input, so the block runs from any system clock.

Top module: `pair_rekey_ctrl`

## Requirements
- R1: Once both presence inputs are high, `rd_req` rises after `PWR_MS` ticks and stays high until `rd_done`. Inserting the second card again after a removal repeats this sequence.
- R2: The pair is valid only when both magic flags are 1, `vol_id_match` is 1 and the two side flags differ (side flag 1 marks the B card, 0 the A card). An invalid pair at `rd_done` lights `err_led` steadily and never raises `mnt_req`.
- R3: A valid pair at `rd_done` raises `mnt_req` on the next cycle and holds it until `mnt_done`. The block is then mounted with every request low and `err_led` low.
- R4: While `err_led` is steady, a debounced press raises `kinit_req` and holds it until `kinit_done`. `mnt_req` follows on the next cycle.
- R5: The button takes effect only after its synchronised level has differed from the debounced level for `DEB_MS` consecutive ticks. A shorter pulse has no effect.
- R6: A debounced press while mounted makes `err_led` go high on entry and then toggle every `BLINK_MS` ticks while the button stays held.
- R7: A release that is debounced before `HOLD_MS` ticks have passed returns to mounted with `err_led` low and raises no request.
- R8: After `HOLD_MS` ticks held, `err_led` goes low and `umnt_req` rises. After `umnt_done`, `kinit_req` follows. After `kinit_done`, `mnt_req` follows.
- R9: Presses made while `kinit_req` or `umnt_req` is outstanding are ignored. They neither end the request nor start a blink after the remount.
- R10: After reset, `card_pwr_on` is 0, `bus_off` is 1 and all requests and `err_led` are 0. `bus_off` stays 1 while power is off and during the power-up interval.
- R11: If either presence input falls, power goes off and the bus is isolated on the next cycle, and any outstanding request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse once per millisecond |
| btn_raw | input | 1 | Raw push-button level, 1 = pressed, asynchronous |
| slot0_present | input | 1 | Card detected in slot 0 |
| slot1_present | input | 1 | Card detected in slot 1 |
| slot0_magic_ok | input | 1 | Slot 0 key block carries the right magic value |
| slot1_magic_ok | input | 1 | Slot 1 key block carries the right magic value |
| slot0_side_b | input | 1 | Slot 0 key block marks its card as B (0 = A) |
| slot1_side_b | input | 1 | Slot 1 key block marks its card as B (0 = A) |
| vol_id_match | input | 1 | The two stored volume identifiers are equal |
| rd_done | input | 1 | Key blocks read, flags valid (one cycle) |
| mnt_done | input | 1 | Host-side mount finished (one cycle) |
| umnt_done | input | 1 | Host-side unmount finished (one cycle) |
| kinit_done | input | 1 | Key initialisation finished (one cycle) |
| card_pwr_on | output | 1 | Card supply switch, 1 = powered |
| bus_off | output | 1 | Bus switch enable, 1 = both cards disconnected |
| rd_req | output | 1 | Request to read both key blocks |
| mnt_req | output | 1 | Request to mount the volume |
| umnt_req | output | 1 | Request to force an unmount |
| kinit_req | output | 1 | Request to generate and write new key blocks |
| err_led | output | 1 | Error indicator, steady or blinking |

## Verification
Every output is a decode of registered state. A handshake done therefore shows as the next request one clock after the edge that samples it, and an insertion shows as `rd_req` `PWR_MS` ticks plus one clock later. A button change reaches the state machine two synchroniser clocks plus `DEB_MS` ticks after it is applied. The blink toggles every `BLINK_MS` ticks and the forced rekey starts `HOLD_MS` ticks after the blink begins. The bench runs a behavioural model that advances on the same edges and compares all seven outputs at every falling edge. The scenario checks also sample at falling edges, after waiting for the awaited output, and bound the blink and hold intervals in clock cycles for a tick on every second clock.

// File: rtl/pair_rekey_pkg.sv
// Shared types for the card pairing and rekey controller.
// Assumes: nothing beyond the consumers importing it.
package pair_rekey_pkg;

    // Controller states; only the decode in the top module gives them meaning.
    typedef enum logic [3:0] {
        ST_IDLE,     // a slot is empty, cards unpowered
        ST_PWRUP,    // cards powered, bus still isolated
        ST_READ,     // key blocks being read
        ST_MOUNT,    // mount requested
        ST_LIVE,     // volume mounted
        ST_ERROR,    // inconsistent pair, steady indicator
        ST_HOLD,     // button held while mounted, blinking
        ST_UNMOUNT,  // forced unmount requested
        ST_INIT      // key initialisation requested
    } ctrl_state_t;

endpackage

// File: rtl/pair_btn_debounce.sv
// Button synchroniser and tick-based debouncer.
// Does: brings the raw level through two flops, then accepts a new level only after
// it has differed from the accepted level for DEB_MS consecutive ticks.
// Emits a one-cycle press pulse together with each accepted rising level.
// Assumes: tick_ms is a single-cycle pulse; DEB_MS >= 2.
module pair_btn_debounce #(
    parameter int DEB_MS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic btn_raw,
    output logic btn_level,
    output logic btn_press
);
    localparam int RW = $clog2(DEB_MS);
    localparam logic [RW-1:0] RUN_LAST = RW'(DEB_MS - 1);

    logic          sync1, sync2;
    logic [RW-1:0] run;

    // Synchronise, count stable-different ticks, accept the level and flag a press.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1     <= 1'b0;
            sync2     <= 1'b0;
            run       <= '0;
            btn_level <= 1'b0;
            btn_press <= 1'b0;
        end else begin
            sync1     <= btn_raw;
            sync2     <= sync1;
            btn_press <= 1'b0;
            if (sync2 == btn_level) begin
                run <= '0;
            end else if (tick_ms) begin
                if (run == RUN_LAST) begin
                    btn_level <= sync2;
                    btn_press <= sync2;
                    run       <= '0;
                end else begin
                    run <= run + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pair_blink_gen.sv
// Blink phase generator for the hold indication.
// Does: while clr is low, toggles its output every BLINK_MS ticks; clr forces the
// phase back to "on" with the count at zero, so a blink always starts lit.
// Assumes: tick_ms is a single-cycle pulse; BLINK_MS >= 2.
module pair_blink_gen #(
    parameter int BLINK_MS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic clr,
    output logic phase_on
);
    localparam int BW = $clog2(BLINK_MS);
    localparam logic [BW-1:0] PHASE_LAST = BW'(BLINK_MS - 1);

    logic [BW-1:0] cnt;

    // Count ticks inside one phase and flip the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt      <= '0;
            phase_on <= 1'b1;
        end else if (tick_ms) begin
            if (cnt == PHASE_LAST) begin
                cnt      <= '0;
                phase_on <= ~phase_on;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pair_check.sv
// Pair consistency decision, purely combinational.
// Does: declares the pair valid when both magic values are right, the volume
// identifiers agree and exactly one card is marked as the B card.
// Assumes: inputs are steady while the read handshake completes.
module pair_check (
    input  logic slot0_magic_ok,
    input  logic slot1_magic_ok,
    input  logic slot0_side_b,
    input  logic slot1_side_b,
    input  logic vol_id_match,
    output logic pair_valid
);
    // One A and one B card, both recognised, same volume.
    always_comb begin
        pair_valid = slot0_magic_ok && slot1_magic_ok && vol_id_match
                     && (slot0_side_b != slot1_side_b);
    end

endmodule

// File: rtl/pair_rekey_ctrl.sv
// Card pairing and rekey controller (top).
// Does: sequences card power and bus isolation, runs the key-block read handshake,
// mounts a consistent pair or lights the error indicator, and interprets the single
// button: immediate key initialisation from the error state, or a blinking
// hold that forces unmount, rekey and remount when held for HOLD_MS ticks.
// Assumes: tick_ms pulses once per millisecond for one cycle; every done input is
// a one-cycle pulse given only while its request is high.
module pair_rekey_ctrl
    import pair_rekey_pkg::*;
#(
    parameter int PWR_MS   = 10,
    parameter int DEB_MS   = 20,
    parameter int BLINK_MS = 250,
    parameter int HOLD_MS  = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic btn_raw,
    input  logic slot0_present,
    input  logic slot1_present,
    input  logic slot0_magic_ok,
    input  logic slot1_magic_ok,
    input  logic slot0_side_b,
    input  logic slot1_side_b,
    input  logic vol_id_match,
    input  logic rd_done,
    input  logic mnt_done,
    input  logic umnt_done,
    input  logic kinit_done,
    output logic card_pwr_on,
    output logic bus_off,
    output logic rd_req,
    output logic mnt_req,
    output logic umnt_req,
    output logic kinit_req,
    output logic err_led
);
    localparam int LONGEST = (HOLD_MS > PWR_MS) ? HOLD_MS : PWR_MS;
    localparam int CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] PWR_LAST  = CW'(PWR_MS - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_MS - 1);

    ctrl_state_t   st, nxt;
    logic [CW-1:0] ms_cnt;
    logic          both_in, pair_valid, btn_level, btn_press, blink_on;

    pair_btn_debounce #(.DEB_MS(DEB_MS)) u_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_ms   (tick_ms),
        .btn_raw   (btn_raw),
        .btn_level (btn_level),
        .btn_press (btn_press)
    );

    pair_blink_gen #(.BLINK_MS(BLINK_MS)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_ms  (tick_ms),
        .clr      (st != ST_HOLD),
        .phase_on (blink_on)
    );

    pair_check u_check (
        .slot0_magic_ok (slot0_magic_ok),
        .slot1_magic_ok (slot1_magic_ok),
        .slot0_side_b   (slot0_side_b),
        .slot1_side_b   (slot1_side_b),
        .vol_id_match   (vol_id_match),
        .pair_valid     (pair_valid)
    );

    assign both_in = slot0_present && slot1_present;

    // Next-state decision; an empty slot overrides everything (R11).
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:    if (both_in) nxt = ST_PWRUP;
            ST_PWRUP:   if (tick_ms && ms_cnt == PWR_LAST) nxt = ST_READ;
            ST_READ:    if (rd_done) nxt = pair_valid ? ST_MOUNT : ST_ERROR;
            ST_MOUNT:   if (mnt_done) nxt = ST_LIVE;
            ST_LIVE:    if (btn_press) nxt = ST_HOLD;
            ST_ERROR:   if (btn_press) nxt = ST_INIT;
            ST_HOLD: begin
                if (!btn_level)                             nxt = ST_LIVE;
                else if (tick_ms && ms_cnt == HOLD_LAST)    nxt = ST_UNMOUNT;
            end
            ST_UNMOUNT: if (umnt_done) nxt = ST_INIT;
            ST_INIT:    if (kinit_done) nxt = ST_MOUNT;
            default:    nxt = ST_IDLE;
        endcase
        if (!both_in) nxt = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Millisecond counter for the power-up wait and the hold window; zeroed on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n || nxt != st)                              ms_cnt <= '0;
        else if (tick_ms && (st == ST_PWRUP || st == ST_HOLD)) ms_cnt <= ms_cnt + 1'b1;
    end

    // Output decode from the registered state.
    always_comb begin
        card_pwr_on = (st != ST_IDLE);
        bus_off     = (st == ST_IDLE) || (st == ST_PWRUP);
        rd_req      = (st == ST_READ);
        mnt_req     = (st == ST_MOUNT);
        umnt_req    = (st == ST_UNMOUNT);
        kinit_req   = (st == ST_INIT);
        err_led     = (st == ST_ERROR) || ((st == ST_HOLD) && blink_on);
    end

endmodule

// File: rtl/pair_rekey_chk.sv
// Protocol checker for the pairing controller, bound to every instance of the top.
// Does: checks power/bus ordering, request exclusivity and the handshake sequencing.
// Assumes: synchronous active-low reset; done inputs are one-cycle pulses.
module pair_rekey_chk (
    input logic clk,
    input logic rst_n,
    input logic slot0_present,
    input logic slot1_present,
    input logic slot0_magic_ok,
    input logic slot1_magic_ok,
    input logic slot0_side_b,
    input logic slot1_side_b,
    input logic vol_id_match,
    input logic rd_done,
    input logic umnt_done,
    input logic kinit_done,
    input logic card_pwr_on,
    input logic bus_off,
    input logic rd_req,
    input logic mnt_req,
    input logic umnt_req,
    input logic kinit_req,
    input logic err_led
);
    // Bus is never connected to an unpowered card.
    p_iso_when_unpowered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !card_pwr_on |-> bus_off);

    // At most one handshake request at a time.
    p_one_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, mnt_req, umnt_req, kinit_req}));

    // An empty slot powers the cards down on the next cycle.
    p_empty_slot_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot0_present && slot1_present) |=> (!card_pwr_on && bus_off && !rd_req));

    // An inconsistent pair lights the indicator and is not mounted.
    p_bad_pair_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_done && slot0_present && slot1_present &&
         !(slot0_magic_ok && slot1_magic_ok && vol_id_match && (slot0_side_b != slot1_side_b)))
        |=> (err_led && !mnt_req));

    // Forced unmount is followed by key initialisation.
    p_unmount_then_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (umnt_req && umnt_done && slot0_present && slot1_present) |=> kinit_req);

    // Key initialisation is followed by a mount request.
    p_init_then_mount_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kinit_req && kinit_done && slot0_present && slot1_present) |=> mnt_req);

    // An outstanding initialisation ends only by its done pulse or a removal.
    p_init_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kinit_req && !kinit_done && slot0_present && slot1_present) |=> kinit_req);

    // An outstanding unmount ends only by its done pulse or a removal.
    p_unmount_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (umnt_req && !umnt_done && slot0_present && slot1_present) |=> umnt_req);

endmodule

bind pair_rekey_ctrl pair_rekey_chk u_chk (.*);

// File: tb/pair_rekey_ctrl_bench.sv
// Bench for the pairing controller: behavioural reference model compared at every
// falling edge, plus scenario checks for each requirement.
module pair_rekey_ctrl_bench;
    localparam int PWR_MS   = 10;
    localparam int DEB_MS   = 20;
    localparam int BLINK_MS = 250;
    localparam int HOLD_MS  = 5000;

    // Model state codes (bench-local).
    localparam int M_OFF = 0, M_WARM = 1, M_RD = 2, M_MNT = 3, M_UP = 4,
                   M_BAD = 5, M_BLINK = 6, M_UMNT = 7, M_KEY = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0, btn_raw = 1'b0;
    logic slot0_present = 1'b0, slot1_present = 1'b0;
    logic slot0_magic_ok = 1'b1, slot1_magic_ok = 1'b1;
    logic slot0_side_b = 1'b0, slot1_side_b = 1'b1, vol_id_match = 1'b1;
    logic rd_done = 1'b0, mnt_done = 1'b0, umnt_done = 1'b0, kinit_done = 1'b0;
    logic card_pwr_on, bus_off, rd_req, mnt_req, umnt_req, kinit_req, err_led;

    int tests = 0, fails = 0, cyc = 0;
    bit kinit_stall = 1'b0;
    int rd_age = 0, mnt_age = 0, umnt_age = 0, key_age = 0;

    always #2 clk = ~clk;  // 250 MHz

    pair_rekey_ctrl #(.PWR_MS(PWR_MS), .DEB_MS(DEB_MS), .BLINK_MS(BLINK_MS),
                      .HOLD_MS(HOLD_MS)) u_pair_rekey_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_raw(btn_raw),
        .slot0_present(slot0_present), .slot1_present(slot1_present),
        .slot0_magic_ok(slot0_magic_ok), .slot1_magic_ok(slot1_magic_ok),
        .slot0_side_b(slot0_side_b), .slot1_side_b(slot1_side_b),
        .vol_id_match(vol_id_match), .rd_done(rd_done), .mnt_done(mnt_done),
        .umnt_done(umnt_done), .kinit_done(kinit_done),
        .card_pwr_on(card_pwr_on), .bus_off(bus_off), .rd_req(rd_req),
        .mnt_req(mnt_req), .umnt_req(umnt_req), .kinit_req(kinit_req),
        .err_led(err_led));

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    bit m_q1, m_q2, m_level, m_press;
    int m_run, m_st, m_cnt;

    always @(posedge clk) begin
        int nx;
        bit both, good;
        if (!rst_n) begin
            m_q1 <= 0; m_q2 <= 0; m_level <= 0; m_press <= 0;
            m_run <= 0; m_st <= M_OFF; m_cnt <= 0;
        end else begin
            m_q1 <= btn_raw;
            m_q2 <= m_q1;
            m_press <= 0;
            if (m_q2 == m_level) m_run <= 0;
            else if (tick_ms) begin
                if (m_run == DEB_MS - 1) begin
                    m_level <= m_q2; m_press <= m_q2; m_run <= 0;
                end else m_run <= m_run + 1;
            end
            both = slot0_present && slot1_present;
            good = slot0_magic_ok && slot1_magic_ok && vol_id_match &&
                   (slot0_side_b != slot1_side_b);
            nx = m_st;
            if (m_st == M_OFF && both) nx = M_WARM;
            if (m_st == M_WARM && tick_ms && m_cnt == PWR_MS - 1) nx = M_RD;
            if (m_st == M_RD && rd_done) nx = good ? M_MNT : M_BAD;
            if (m_st == M_MNT && mnt_done) nx = M_UP;
            if (m_st == M_UP && m_press) nx = M_BLINK;
            if (m_st == M_BAD && m_press) nx = M_KEY;
            if (m_st == M_BLINK) begin
                if (!m_level) nx = M_UP;
                else if (tick_ms && m_cnt == HOLD_MS - 1) nx = M_UMNT;
            end
            if (m_st == M_UMNT && umnt_done) nx = M_KEY;
            if (m_st == M_KEY && kinit_done) nx = M_MNT;
            if (!both) nx = M_OFF;
            if (nx != m_st) m_cnt <= 0;
            else if (tick_ms && (m_st == M_WARM || m_st == M_BLINK)) m_cnt <= m_cnt + 1;
            m_st <= nx;
        end
    end

    // Compare, tick, auto-responders and watchdog at every falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R10 model card_pwr_on", card_pwr_on, m_st != M_OFF);
            chk("R10 model bus_off", bus_off, m_st == M_OFF || m_st == M_WARM);
            chk("R1 model rd_req", rd_req, m_st == M_RD);
            chk("R3 model mnt_req", mnt_req, m_st == M_MNT);
            chk("R8 model umnt_req", umnt_req, m_st == M_UMNT);
            chk("R4 model kinit_req", kinit_req, m_st == M_KEY);
            chk("R6 model err_led", err_led,
                m_st == M_BAD || (m_st == M_BLINK && ((m_cnt / BLINK_MS) % 2 == 0)));
        end
        tick_ms = (cyc % 2 == 0);
        rd_age   = rd_req    ? rd_age + 1   : 0;
        mnt_age  = mnt_req   ? mnt_age + 1  : 0;
        umnt_age = umnt_req  ? umnt_age + 1 : 0;
        key_age  = kinit_req ? key_age + 1  : 0;
        rd_done    = (rd_age == 4);
        mnt_done   = (mnt_age == 4);
        umnt_done  = (umnt_age == 4);
        kinit_done = (key_age >= 4) && !kinit_stall && (key_age == 4 || key_age > 4);
        if (kinit_done) key_age = -1000000;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        int t0;
        step(5);
        rst_n = 1'b1;
        step(2);
        chk("R10 reset power", card_pwr_on, 0);
        chk("R10 reset bus isolated", bus_off, 1);
        chk("R10 reset requests", {rd_req, mnt_req, umnt_req, kinit_req}, 0);
        chk("R10 reset led", err_led, 0);

        // Valid pair inserted.
        slot0_present = 1; slot1_present = 1;
        step(3);
        chk("R10 powered but isolated", {card_pwr_on, bus_off}, 3);
        for (int i = 0; i < 200 && !rd_req; i++) step(1);
        chk("R1 read requested", rd_req, 1);
        chk("R1 bus connected for read", bus_off, 0);
        for (int i = 0; i < 50 && !mnt_req; i++) step(1);
        chk("R3 mount requested", mnt_req, 1);
        for (int i = 0; i < 50 && mnt_req; i++) step(1);
        step(2);
        chk("R3 mounted quiet", {rd_req, mnt_req, umnt_req, kinit_req, err_led}, 0);

        // Short glitch: 10 ticks only.
        btn_raw = 1; step(20); btn_raw = 0; step(100);
        chk("R5 glitch ignored", err_led, 0);

        // Press, watch one blink phase, release early.
        btn_raw = 1;
        for (int i = 0; i < 200 && !err_led; i++) step(1);
        chk("R6 blink starts lit", err_led, 1);
        t0 = cyc;
        for (int i = 0; i < 1000 && err_led; i++) step(1);
        chk("R6 lit phase near BLINK_MS ticks", (cyc - t0 >= 495 && cyc - t0 <= 505), 1);
        step(300);
        btn_raw = 0; step(120);
        chk("R7 cancel leaves led off", err_led, 0);
        chk("R7 cancel raises no request", {umnt_req, kinit_req, mnt_req}, 0);

        // Full hold.
        btn_raw = 1;
        for (int i = 0; i < 200 && !err_led; i++) step(1);
        t0 = cyc;
        for (int i = 0; i < 12000 && !umnt_req; i++) step(1);
        chk("R8 unmount requested", umnt_req, 1);
        chk("R8 hold time near HOLD_MS ticks", (cyc - t0 >= 9990 && cyc - t0 <= 10010), 1);
        chk("R8 blink stopped", err_led, 0);
        for (int i = 0; i < 50 && !kinit_req; i++) step(1);
        chk("R8 rekey after unmount", kinit_req, 1);
        for (int i = 0; i < 50 && !mnt_req; i++) step(1);
        chk("R8 remount after rekey", mnt_req, 1);
        btn_raw = 0; step(120);

        // Removal.
        slot1_present = 0; step(1);
        chk("R11 removal powers down", {card_pwr_on, bus_off}, 1);
        step(5);

        // Three inconsistent pairs.
        for (int k = 0; k < 3; k++) begin
            slot0_magic_ok = (k != 0);
            slot1_side_b   = (k != 1);
            vol_id_match   = (k != 2);
            slot0_present = 1; slot1_present = 1;
            for (int i = 0; i < 200 && !rd_req; i++) step(1);
            chk("R1 read repeated on insertion", rd_req, 1);
            for (int i = 0; i < 50 && rd_req; i++) step(1);
            step(1);
            chk("R2 invalid pair lights led", err_led, 1);
            chk("R2 invalid pair not mounted", mnt_req, 0);
            if (k < 2) begin
                slot0_present = 0; step(5);
            end
        end

        // Initialise from error; presses during the request are ignored.
        kinit_stall = 1;
        btn_raw = 1;
        for (int i = 0; i < 200 && !kinit_req; i++) step(1);
        chk("R4 press in error starts init", kinit_req, 1);
        btn_raw = 0; step(100);
        btn_raw = 1; step(100);
        chk("R9 init still outstanding", kinit_req, 1);
        chk("R9 no blink during init", err_led, 0);
        kinit_stall = 0;
        for (int i = 0; i < 50 && !mnt_req; i++) step(1);
        chk("R4 mount after init", mnt_req, 1);
        step(100);
        chk("R9 ignored press gives no blink", err_led, 0);
        chk("R9 ignored press gives no unmount", umnt_req, 0);
        btn_raw = 0; step(100);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule